// File: doc/BRIEF.md
# Accumulator ALU with Status Flag Byte

This block is the arithmetic and logic stage of an 8-bit accumulator machine. Each cycle it can take the accumulator, a second operand, an operation code and the current flag byte. One clock edge later it returns the new accumulator value and a new flag byte that holds sign, zero, auxiliary carry, parity and carry. The rule that updates each flag depends on the operation. Logic operations force the carry bits. Increment and decrement keep the carry. The rotates touch carry alone. A decimal adjust corrects a binary sum of two packed BCD bytes.

Beside the 8-bit path there is a 16-bit register-pair adder with its own request strobe. It returns a 16-bit sum and changes only the carry bit of the flag byte. Register file access and instruction decode sit in the surrounding core. That core feeds this block and writes the results back.

Top module: `alu_psw_top`

## Requirements
- R1: Operation codes on `op_code` are: 0 add, 1 add with carry-in CY, 2 subtract, 3 subtract with borrow-in CY, 4 compare, 5 increment, 6 decrement, 7 AND, 8 OR, 9 XOR, 10 rotate left, 11 rotate right, 12 rotate left through carry, 13 rotate right through carry, 14 decimal adjust, 15 pass. Add and subtract produce the 8-bit result modulo 256. CY is the carry out of bit 7 for adds and the borrow (difference below zero) for subtracts.
- R2: The flag byte keeps S in bit 7, Z in bit 6, AC in bit 4, P in bit 2 and CY in bit 0, and drives bits 5, 3 and 1 as 0. Where an operation sets S, Z and P, S is result bit 7, Z is 1 for a zero result and P is 1 for an even count of ones.
- R3: For adds, AC is the carry out of the low nibble, counting the carry-in. For subtract, subtract with borrow and compare, AC is the carry out of the low nibble of acc + ~operand + (1 - borrow_in).
- R4: Compare returns the accumulator unchanged as its result. Its flags are those that subtract would give.
- R5: Increment and decrement update S, Z, P and AC and keep CY. AC is 1 when the low nibble was F before increment, and 1 when the low nibble was nonzero before decrement.
- R6: AND sets AC and clears CY. OR and XOR clear both AC and CY.
- R7: The rotates leave S, Z, AC and P as given. Rotate left and rotate right copy the bit shifted out into the vacated bit and into CY. The carry rotates shift the old CY in and put the bit shifted out into CY.
- R8: Decimal adjust adds 06h when the low nibble exceeds 9 or AC is set. It then adds 60h when the high nibble of that sum exceeds 9, when that sum overflowed, or when CY is set, and CY becomes 1 exactly when the 60h is added. AC is the carry out of the low nibble in the first step. S, Z and P follow the result, so 4Bh with clear flags gives 51h.
- R9: A pair request returns `pair_hl + pair_rp` modulo 65536 on `pair_sum` and sets CY to the carry out of bit 15. A pair request without an 8-bit request passes S, Z, AC and P from `flags_in` and leaves `result` unchanged.
- R10: When an 8-bit request and a pair request come in the same cycle, CY comes from the pair add. S, Z, AC and P come from the 8-bit operation.
- R11: The outputs change on the clock edge that samples a request. `out_vld` is high for exactly the cycles that follow a request. `result` holds its value unless an 8-bit request is sampled, and `pair_sum` holds its value unless a pair request is sampled.
- R12: Synchronous active-high reset clears `out_vld`, `result`, `flags_out` and `pair_sum` to 0.
- R13: Code 15 returns the accumulator unchanged and passes all five flags through from `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_go | input | 1 | 8-bit operation request |
| op_code | input | 4 | Operation code (R1) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand |
| flags_in | input | 8 | Current flag byte |
| pair_go | input | 1 | 16-bit pair add request |
| pair_hl | input | 16 | First 16-bit addend |
| pair_rp | input | 16 | Second 16-bit addend |
| out_vld | output | 1 | Results updated by a request on the previous edge |
| result | output | 8 | New accumulator value |
| flags_out | output | 8 | New flag byte |
| pair_sum | output | 16 | 16-bit pair sum |

## Verification
The 8-bit operation and the 16-bit pair add can be requested in the same cycle, and both claim the carry bit. The bench drives both strobes together with operations whose own carry differs from the pair carry: an add that overflows beside a pair add that does not, and a pair add that overflows beside a logic operation that clears CY. It then expects CY from the pair add, S, Z, AC and P from the 8-bit operation, and both data results updated. A pseudo-random sweep also raises the pair strobe on a regular share of 8-bit requests across every opcode, so the merge is judged under every flag rule.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DW     = 8;
    localparam int NIB    = 4;
    localparam int OPW    = 4;

    localparam int FB_S   = 7;
    localparam int FB_Z   = 6;
    localparam int FB_AC  = 4;
    localparam int FB_P   = 2;
    localparam int FB_CY  = 0;

    typedef logic [DW-1:0] byte_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_AND = 4'd7,
        OP_OR  = 4'd8,
        OP_XOR = 4'd9,
        OP_ROL = 4'd10,
        OP_ROR = 4'd11,
        OP_RCL = 4'd12,
        OP_RCR = 4'd13,
        OP_DAJ = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } flag_s;

    function automatic flag_s unpack_flags(input byte_t b);
        flag_s f;
        f.s  = b[FB_S];
        f.z  = b[FB_Z];
        f.ac = b[FB_AC];
        f.p  = b[FB_P];
        f.cy = b[FB_CY];
        return f;
    endfunction

    function automatic byte_t pack_flags(input flag_s f);
        byte_t b;
        b        = '0;
        b[FB_S]  = f.s;
        b[FB_Z]  = f.z;
        b[FB_AC] = f.ac;
        b[FB_P]  = f.p;
        b[FB_CY] = f.cy;
        return b;
    endfunction

    function automatic logic even_ones(input byte_t b);
        return ~^b;
    endfunction

endpackage

// File: rtl/bcd_adjust.sv
module bcd_adjust
    import alu_pkg::*;
(
    input  byte_t a,
    input  logic  ac_in,
    input  logic  cy_in,
    output byte_t res,
    output logic  ac_out,
    output logic  cy_out
);
    localparam logic [NIB-1:0] NIB_MAX = 4'd9;
    localparam logic [NIB:0]   LO_ADD  = 5'd6;
    localparam byte_t          HI_ADD  = 8'h60;

    logic          lo_fix;
    logic          hi_fix;
    logic [NIB:0]  nib_sum;
    logic [DW:0]   step1;

    always_comb begin
        lo_fix  = (a[NIB-1:0] > NIB_MAX) || ac_in;
        nib_sum = {1'b0, a[NIB-1:0]} + (lo_fix ? LO_ADD : '0);
        step1   = {1'b0, a} + {{(DW-NIB){1'b0}}, (lo_fix ? LO_ADD : '0)};
        hi_fix  = cy_in || step1[DW] || (step1[DW-1:NIB] > NIB_MAX);
        res     = step1[DW-1:0] + (hi_fix ? HI_ADD : '0);
        ac_out  = nib_sum[NIB];
        cy_out  = hi_fix;
    end
endmodule

// File: rtl/pair_adder.sv
module pair_adder #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] a,
    input  logic [PW-1:0] b,
    output logic [PW-1:0] sum,
    output logic          cy
);
    logic [PW:0] wide;

    always_comb begin
        wide = {1'b0, a} + {1'b0, b};
        sum  = wide[PW-1:0];
        cy   = wide[PW];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu_pkg::*;
(
    input  alu_op_e op,
    input  byte_t   a,
    input  byte_t   b,
    input  flag_s   fi,
    output byte_t   res,
    output flag_s   fo
);
    logic [DW:0]  wsum;
    logic [NIB:0] nsum;
    logic         cin;
    byte_t        bx;
    byte_t        fval;
    logic         upd_szp;

    byte_t        daj_res;
    logic         daj_ac;
    logic         daj_cy;

    bcd_adjust u_daj (
        .a      (a),
        .ac_in  (fi.ac),
        .cy_in  (fi.cy),
        .res    (daj_res),
        .ac_out (daj_ac),
        .cy_out (daj_cy)
    );

    always_comb begin
        res     = a;
        fo      = fi;
        wsum    = '0;
        nsum    = '0;
        cin     = 1'b0;
        bx      = b;
        upd_szp = 1'b1;
        fval    = '0;

        case (op)
            OP_ADD, OP_ADC: begin
                cin   = (op == OP_ADC) && fi.cy;
                wsum  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
                nsum  = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
                res   = wsum[DW-1:0];
                fo.cy = wsum[DW];
                fo.ac = nsum[NIB];
            end
            OP_SUB, OP_SBB, OP_CMP: begin
                cin   = !((op == OP_SBB) && fi.cy);
                bx    = ~b;
                wsum  = {1'b0, a} + {1'b0, bx} + {{DW{1'b0}}, cin};
                nsum  = {1'b0, a[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cin};
                res   = (op == OP_CMP) ? a : wsum[DW-1:0];
                fo.cy = !wsum[DW];
                fo.ac = nsum[NIB];
            end
            OP_INC: begin
                wsum  = {1'b0, a} + {{DW{1'b0}}, 1'b1};
                nsum  = {1'b0, a[NIB-1:0]} + {{NIB{1'b0}}, 1'b1};
                res   = wsum[DW-1:0];
                fo.ac = nsum[NIB];
            end
            OP_DEC: begin
                wsum  = {1'b0, a} + {1'b0, {DW{1'b1}}};
                nsum  = {1'b0, a[NIB-1:0]} + {1'b0, {NIB{1'b1}}};
                res   = wsum[DW-1:0];
                fo.ac = nsum[NIB];
            end
            OP_AND: begin
                res   = a & b;
                fo.cy = 1'b0;
                fo.ac = 1'b1;
            end
            OP_OR: begin
                res   = a | b;
                fo.cy = 1'b0;
                fo.ac = 1'b0;
            end
            OP_XOR: begin
                res   = a ^ b;
                fo.cy = 1'b0;
                fo.ac = 1'b0;
            end
            OP_ROL: begin
                res     = {a[DW-2:0], a[DW-1]};
                fo.cy   = a[DW-1];
                upd_szp = 1'b0;
            end
            OP_ROR: begin
                res     = {a[0], a[DW-1:1]};
                fo.cy   = a[0];
                upd_szp = 1'b0;
            end
            OP_RCL: begin
                res     = {a[DW-2:0], fi.cy};
                fo.cy   = a[DW-1];
                upd_szp = 1'b0;
            end
            OP_RCR: begin
                res     = {fi.cy, a[DW-1:1]};
                fo.cy   = a[0];
                upd_szp = 1'b0;
            end
            OP_DAJ: begin
                res   = daj_res;
                fo.ac = daj_ac;
                fo.cy = daj_cy;
            end
            default: begin
                upd_szp = 1'b0;
            end
        endcase

        fval = (op == OP_CMP) ? wsum[DW-1:0] : res;
        if (upd_szp) begin
            fo.s = fval[DW-1];
            fo.z = (fval == '0);
            fo.p = even_ones(fval);
        end
    end
endmodule

// File: rtl/alu_psw_top.sv
module alu_psw_top
    import alu_pkg::*;
#(
    parameter int PAIR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_go,
    input  logic [OPW-1:0]    op_code,
    input  logic [DW-1:0]     acc_in,
    input  logic [DW-1:0]     opnd_in,
    input  logic [DW-1:0]     flags_in,
    input  logic              pair_go,
    input  logic [PAIR_W-1:0] pair_hl,
    input  logic [PAIR_W-1:0] pair_rp,
    output logic              out_vld,
    output logic [DW-1:0]     result,
    output logic [DW-1:0]     flags_out,
    output logic [PAIR_W-1:0] pair_sum
);
    flag_s             fi;
    flag_s             core_fo;
    flag_s             nxt_f;
    byte_t             core_res;
    logic [PAIR_W-1:0] p_sum;
    logic              p_cy;

    assign fi = unpack_flags(flags_in);

    alu8_core u_core (
        .op  (alu_op_e'(op_code)),
        .a   (acc_in),
        .b   (opnd_in),
        .fi  (fi),
        .res (core_res),
        .fo  (core_fo)
    );

    pair_adder #(.PW(PAIR_W)) u_pair (
        .a   (pair_hl),
        .b   (pair_rp),
        .sum (p_sum),
        .cy  (p_cy)
    );

    always_comb begin
        nxt_f = op_go ? core_fo : fi;
        if (pair_go) begin
            nxt_f.cy = p_cy;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld   <= 1'b0;
            result    <= '0;
            flags_out <= '0;
            pair_sum  <= '0;
        end else begin
            out_vld <= op_go || pair_go;
            if (op_go) begin
                result <= core_res;
            end
            if (op_go || pair_go) begin
                flags_out <= pack_flags(nxt_f);
            end
            if (pair_go) begin
                pair_sum <= p_sum;
            end
        end
    end
endmodule

// File: rtl/alu_psw_chk.sv
module alu_psw_chk
    import alu_pkg::*;
#(
    parameter int PAIR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              op_go,
    input logic [OPW-1:0]    op_code,
    input logic [DW-1:0]     acc_in,
    input logic [DW-1:0]     flags_in,
    input logic              pair_go,
    input logic              out_vld,
    input logic [DW-1:0]     result,
    input logic [DW-1:0]     flags_out,
    input logic [PAIR_W-1:0] pair_sum
);
    localparam byte_t DC_MASK  = 8'h2A;
    localparam byte_t SZAP_MSK = 8'hD4;

    // R2
    dc_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (flags_out & DC_MASK) == '0);

    // R11
    vld_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go || pair_go) |=> out_vld);

    // R11
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !(op_go || pair_go) |=> !out_vld);

    // R11
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op_go |=> $stable(result));

    // R9
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pair_go |=> $stable(pair_sum));

    // R4
    cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_code == OP_CMP) |=> result == $past(acc_in));

    // R7
    rot_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_code >= OP_ROL && op_code <= OP_RCR)
        |=> (flags_out & SZAP_MSK) == ($past(flags_in) & SZAP_MSK));

    // R5
    incdec_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && !pair_go && (op_code == OP_INC || op_code == OP_DEC))
        |=> flags_out[FB_CY] == $past(flags_in[FB_CY]));

    // R6
    and_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && !pair_go && op_code == OP_AND)
        |=> (flags_out[FB_AC] && !flags_out[FB_CY]));

    // R9
    pair_only_chk: assert property (@(posedge clk) disable iff (rst)
        (pair_go && !op_go)
        |=> (flags_out & SZAP_MSK) == ($past(flags_in) & SZAP_MSK));

    // R2
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && ((op_code <= OP_XOR && op_code != OP_CMP) || op_code == OP_DAJ))
        |=> flags_out[FB_Z] == (result == '0));
endmodule

bind alu_psw_top alu_psw_chk #(.PAIR_W(PAIR_W)) i_chk (.*);

// File: tb/test_alu_psw_top.sv
module test_alu_psw_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_go;
    logic [3:0]  op_code;
    logic [7:0]  acc_in;
    logic [7:0]  opnd_in;
    logic [7:0]  flags_in;
    logic        pair_go;
    logic [15:0] pair_hl;
    logic [15:0] pair_rp;
    logic        out_vld;
    logic [7:0]  result;
    logic [7:0]  flags_out;
    logic [15:0] pair_sum;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [7:0]  res;
        logic [7:0]  flg;
        logic [15:0] sum;
        bit          chk_res;
        bit          chk_sum;
        string       tag;
    } exp_t;

    exp_t sb[$];

    alu_psw_top i_alu_psw_top (
        .clk       (clk),
        .rst       (rst),
        .op_go     (op_go),
        .op_code   (op_code),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .flags_in  (flags_in),
        .pair_go   (pair_go),
        .pair_hl   (pair_hl),
        .pair_rp   (pair_rp),
        .out_vld   (out_vld),
        .result    (result),
        .flags_out (flags_out),
        .pair_sum  (pair_sum)
    );

    always #5 clk = ~clk;

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    // Reference model written from the requirements (R1..R8, R13)
    function automatic void model(input int op, input int a, input int b,
                                  input logic [7:0] f,
                                  output logic [7:0] r_o, output logic [7:0] f_o);
        int r, val, s, c, cy, ac, sf, zf, pf;
        bit szp, lo, hi;
        cy = f[0]; ac = f[4]; sf = f[7]; zf = f[6]; pf = f[2];
        szp = 1; r = a; val = -1;
        case (op)
            0, 1: begin
                c = (op == 1) ? int'(f[0]) : 0;
                s = a + b + c; r = s % 256; cy = (s > 255);
                ac = ((a % 16) + (b % 16) + c) > 15;
            end
            2, 3, 4: begin
                c = (op == 3) ? int'(f[0]) : 0;
                s = a - b - c; cy = (s < 0);
                ac = ((a % 16) + 15 - (b % 16) + 1 - c) > 15;
                val = (s + 512) % 256;
                r = (op == 4) ? a : val;
            end
            5: begin r = (a + 1) % 256; ac = (a % 16) == 15; end
            6: begin r = (a + 255) % 256; ac = (a % 16) != 0; end
            7: begin r = a & b; cy = 0; ac = 1; end
            8: begin r = a | b; cy = 0; ac = 0; end
            9: begin r = a ^ b; cy = 0; ac = 0; end
            10: begin r = (a * 2) % 256 + a / 128; cy = a / 128; szp = 0; end
            11: begin r = a / 2 + (a % 2) * 128; cy = a % 2; szp = 0; end
            12: begin r = (a * 2) % 256 + int'(f[0]); cy = a / 128; szp = 0; end
            13: begin r = a / 2 + int'(f[0]) * 128; cy = a % 2; szp = 0; end
            14: begin
                lo = ((a % 16) > 9) || f[4];
                s  = a + (lo ? 6 : 0);
                ac = lo && ((a % 16) + 6 > 15);
                hi = f[0] || (s > 255) || (((s % 256) / 16) > 9);
                r  = ((s % 256) + (hi ? 96 : 0)) % 256;
                cy = hi;
            end
            default: szp = 0;
        endcase
        if (val < 0) val = r;
        if (szp) begin
            sf = (val >= 128); zf = (val == 0); pf = (ones(val) % 2 == 0);
        end
        r_o = r[7:0];
        f_o = {sf[0], zf[0], 1'b0, ac[0], 1'b0, pf[0], 1'b0, cy[0]};
    endfunction

    task automatic issue(input bit ogo, input int op, input int a, input int b,
                         input logic [7:0] f, input bit pgo,
                         input int pa, input int pb, input string tag);
        exp_t e;
        logic [7:0] r8, f8;
        int ps;
        @(negedge clk);
        op_go = ogo; op_code = op[3:0]; acc_in = a[7:0]; opnd_in = b[7:0];
        flags_in = f; pair_go = pgo; pair_hl = pa[15:0]; pair_rp = pb[15:0];
        if (ogo) model(op, a, b, f, r8, f8);
        else begin
            r8 = 8'h00;
            f8 = f & 8'hD5;
        end
        ps = (pa % 65536) + (pb % 65536);
        if (pgo) f8[0] = (ps > 65535);
        e.res = r8; e.flg = f8; e.sum = ps[15:0];
        e.chk_res = ogo; e.chk_sum = pgo; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        op_go = 0; pair_go = 0;
    endtask

    task automatic chk_rst(input string tag);
        checks++;
        if (out_vld !== 1'b0 || result !== 8'h00 || flags_out !== 8'h00 || pair_sum !== 16'h0) begin
            errors++;
            $display("FAIL %s vld=%b res=%h flg=%h sum=%h expected 0 0 00 0000",
                     tag, out_vld, result, flags_out, pair_sum);
        end
    endtask

    // monitor / scoreboard
    initial begin
        exp_t e;
        bit bad;
        forever begin
            @(posedge clk);
            #2;
            if (!rst && out_vld === 1'b1) begin
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R11 out_vld with nothing expected res=%h flg=%h", result, flags_out);
                end else begin
                    e = sb.pop_front();
                    bad = (flags_out !== e.flg);
                    if (e.chk_res && result !== e.res) bad = 1;
                    if (e.chk_sum && pair_sum !== e.sum) bad = 1;
                    if (bad) begin
                        errors++;
                        $display("FAIL %s res=%h/%h flg=%h/%h sum=%h/%h (actual/expected)",
                                 e.tag, result, e.res, flags_out, e.flg, pair_sum, e.sum);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        rst = 1; op_go = 0; op_code = 0; acc_in = 0; opnd_in = 0; flags_in = 0;
        pair_go = 0; pair_hl = 0; pair_rp = 0;
        repeat (3) @(posedge clk);
        #2 chk_rst("R12 reset state");
        @(negedge clk);
        rst = 0;
        @(posedge clk); #2 chk_rst("R11 idle after reset");

        issue(1, 0, 8'h12, 8'h39, 8'h00, 0, 0, 0, "R1 add 12+39");
        issue(1, 14, 8'h4B, 0, 8'h00, 0, 0, 0, "R8 adjust 4B->51");
        issue(1, 14, 8'h99, 0, 8'h11, 0, 0, 0, "R8 adjust with AC and CY set");
        issue(1, 14, 8'hFA, 0, 8'h00, 0, 0, 0, "R8 adjust overflow path");
        issue(1, 0, 8'h80, 8'h80, 8'h00, 0, 0, 0, "R1 add carry zero");
        issue(1, 1, 8'h10, 8'h10, 8'h01, 0, 0, 0, "R1 add with carry 21");
        issue(1, 0, 8'h0F, 8'h01, 8'h00, 0, 0, 0, "R3 add low nibble carry");
        issue(1, 2, 8'h10, 8'h20, 8'h00, 0, 0, 0, "R1 subtract borrow");
        issue(1, 3, 8'h20, 8'h0F, 8'h01, 0, 0, 0, "R3 subtract with borrow 10");
        issue(1, 4, 8'h17, 8'h17, 8'h00, 0, 0, 0, "R4 compare equal");
        issue(1, 4, 8'h10, 8'h17, 8'h00, 0, 0, 0, "R4 compare below");
        issue(1, 5, 8'hFF, 0, 8'h01, 0, 0, 0, "R5 increment FF keeps CY");
        issue(1, 6, 8'h00, 0, 8'h00, 0, 0, 0, "R5 decrement 00 keeps CY");
        issue(1, 6, 8'h10, 0, 8'h01, 0, 0, 0, "R5 decrement 10");
        issue(1, 7, 8'h3C, 8'h0F, 8'h01, 0, 0, 0, "R6 AND");
        issue(1, 8, 8'h10, 8'h17, 8'h11, 0, 0, 0, "R6 OR");
        issue(1, 9, 8'h17, 8'h17, 8'h11, 0, 0, 0, "R6 XOR zero");
        issue(1, 10, 8'h03, 0, 8'hD4, 0, 0, 0, "R7 rotate left");
        issue(1, 11, 8'h03, 0, 8'h00, 0, 0, 0, "R7 rotate right 81");
        issue(1, 12, 8'h03, 0, 8'h01, 0, 0, 0, "R7 rotate left through carry");
        issue(1, 13, 8'h02, 0, 8'h01, 0, 0, 0, "R7 rotate right through carry");
        issue(1, 15, 8'h5A, 8'hFF, 8'hFF, 0, 0, 0, "R13 pass");
        issue(0, 0, 0, 0, 8'hD4, 1, 16'hFFFF, 16'h0001, "R9 pair add carry");
        issue(0, 0, 0, 0, 8'h01, 1, 16'h2040, 16'h3010, "R9 pair add no carry");
        issue(1, 0, 8'hF0, 8'h20, 8'h00, 1, 16'h0001, 16'h0002, "R10 add carry vs pair no carry");
        issue(1, 8, 8'h00, 8'h00, 8'h00, 1, 16'h8000, 16'h8000, "R10 OR vs pair carry");

        lf = 16'hACE1;
        for (int i = 0; i < 480; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            issue(1, i % 16, lf[7:0], lf[15:8], {lf[3:0], lf[7:4]} ^ 8'h5A,
                  (i % 5) == 0, {lf[7:0], lf[15:8]}, int'(lf) * 3,
                  "R1 R2 R10 sweep");
        end

        repeat (4) @(posedge clk);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL R11 %0d results missing, expected 0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule